// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block sits beside a two-port shared memory. It watches the access controls of both ports and raises a cross-port interrupt for message passing. The two highest word addresses serve as mailboxes. The highest word belongs to the right port. The word just below it belongs to the left port. When one port writes into the mailbox that the other port owns, the owner's active-low interrupt line is driven low. The line returns high when the owner reads its own mailbox.

Each port presents a select, a write strobe, an output enable, a word address and a busy flag. The busy flag marks that the port has lost an arbitration for the location it is addressing. A port that sees busy can neither raise the other side's interrupt nor clear its own. The message contents and the storage array are not part of this block. It only turns address-specific side effects into two registered flag outputs.

All inputs are sampled on the rising clock edge, and the flags change one clock after the qualifying access.

Top module: `mbx_irq_top`

## Requirements
- R1: With address width ADDR_W, the right mailbox is the all-ones address and the left mailbox is the all-ones address minus one (for the default ADDR_W=16 these are 0xFFFF and 0xFFFE).
- R2: A left-port write (leftSel=1, leftWr=1, leftBusy=0) to the right mailbox drives rightIntN low one clock later.
- R3: A right-port write (rightSel=1, rightWr=1, rightBusy=0) to the left mailbox drives leftIntN low one clock later.
- R4: A read of a port's own mailbox (sel=1, wr=0, oe=1, busy=0) drives that port's interrupt line high one clock later. The same read with oe=0 leaves the line unchanged.
- R5: A port reading the other port's mailbox leaves both interrupt lines unchanged.
- R6: While a port's busy input is 1, its write to the other port's mailbox does not drive the other interrupt low.
- R7: While a port's busy input is 1, its read of its own mailbox does not clear its interrupt.
- R8: If a set and a clear of the same interrupt occur in the same cycle, the line goes low, because the set wins.
- R9: Both interrupt lines are registered and are high (inactive) during and after reset.
- R10: A port writing its own mailbox changes neither interrupt line.
- R11: Accesses with select low, and accesses to any address other than the two mailboxes, change neither interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| leftSel | input | 1 | Left port access select, active high |
| leftWr | input | 1 | Left port write strobe (1 = write, 0 = read) |
| leftOe | input | 1 | Left port output enable, active high |
| leftAddr | input | ADDR_W | Left port word address |
| leftBusy | input | 1 | Left port lost arbitration, active high |
| rightSel | input | 1 | Right port access select, active high |
| rightWr | input | 1 | Right port write strobe (1 = write, 0 = read) |
| rightOe | input | 1 | Right port output enable, active high |
| rightAddr | input | ADDR_W | Right port word address |
| rightBusy | input | 1 | Right port lost arbitration, active high |
| leftIntN | output | 1 | Interrupt to the left port, active low |
| rightIntN | output | 1 | Interrupt to the right port, active low |

## Verification
The bench covers several cases that a wrong design would get wrong. A simultaneous set and clear of one flag must leave the line low; a design that lets the clear win would release it. A cross-mailbox read must not touch either flag; a decoder that ignores ownership would clear the wrong flag. Busy must block both the set path and the clear path separately, and a read with output enable low must not count as a clear. A self-write to a port's own mailbox must be ignored; a decoder that does not check the writer would raise the port's own interrupt. A long pseudo-random phase then biases addresses toward the two mailboxes so that these cases collide in many combinations, and a behavioural model compares every cycle.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int NUM_SIDES = 2;
  localparam int SIDE_LEFT = 0;
  localparam int SIDE_RIGHT = 1;

  typedef struct packed {
    logic [NUM_SIDES-1:0] raiseReq;
    logic [NUM_SIDES-1:0] dropReq;
  } flag_strobe_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] OWN_BOX = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
  input  logic              portSel,
  input  logic              portWr,
  input  logic              portOe,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              portBusy,
  output logic              peerRaise,
  output logic              ownDrop
);
  logic granted;
  logic hitOwn;
  logic hitPeer;

  always_comb begin
    granted   = portSel && !portBusy;
    hitOwn    = (portAddr == OWN_BOX);
    hitPeer   = (portAddr == PEER_BOX);
    peerRaise = granted && portWr && hitPeer;
    ownDrop   = granted && !portWr && portOe && hitOwn;
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [NUM_SIDES-1:0]             sideSel,
  input  logic [NUM_SIDES-1:0]             sideWr,
  input  logic [NUM_SIDES-1:0]             sideOe,
  input  logic [NUM_SIDES-1:0][ADDR_W-1:0] sideAddr,
  input  logic [NUM_SIDES-1:0]             sideBusy,
  output flag_strobe_t                     strobes
);
  localparam logic [ADDR_W-1:0] RIGHT_BOX = '1;
  localparam logic [ADDR_W-1:0] LEFT_BOX = RIGHT_BOX - 1'b1;

  logic [NUM_SIDES-1:0] peerRaise;
  logic [NUM_SIDES-1:0] ownDrop;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam logic [ADDR_W-1:0] OWN_BOX = (s == SIDE_RIGHT) ? RIGHT_BOX : LEFT_BOX;
    localparam logic [ADDR_W-1:0] PEER_BOX = (s == SIDE_RIGHT) ? LEFT_BOX : RIGHT_BOX;
    mbx_port_decode #(
      .ADDR_W(ADDR_W),
      .OWN_BOX(OWN_BOX),
      .PEER_BOX(PEER_BOX)
    ) u_dec (
      .portSel(sideSel[s]),
      .portWr(sideWr[s]),
      .portOe(sideOe[s]),
      .portAddr(sideAddr[s]),
      .portBusy(sideBusy[s]),
      .peerRaise(peerRaise[s]),
      .ownDrop(ownDrop[s])
    );
    // A write by side s raises the flag of the opposite side.
    assign strobes.raiseReq[NUM_SIDES-1-s] = peerRaise[s];
    assign strobes.dropReq[s] = ownDrop[s];
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import mbx_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  flag_strobe_t         strobes,
  output logic [NUM_SIDES-1:0] flagN
);
  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)
        flagN[s] <= 1'b1;
      else if (strobes.raiseReq[s])
        flagN[s] <= 1'b0;
      else if (strobes.dropReq[s])
        flagN[s] <= 1'b1;
    end

    // R8: a set wins even when a clear arrives in the same cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
      strobes.raiseReq[s] |=> !flagN[s]);
    // R4: a lone clear releases the line
    p_clear_high_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.dropReq[s] && !strobes.raiseReq[s]) |=> flagN[s]);
    // R5: with no strobe the flag keeps its level
    p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.dropReq[s] && !strobes.raiseReq[s]) |=> $stable(flagN[s]));
  end
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftSel,
  input  logic              leftWr,
  input  logic              leftOe,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftBusy,
  input  logic              rightSel,
  input  logic              rightWr,
  input  logic              rightOe,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightBusy,
  output logic              leftIntN,
  output logic              rightIntN
);
  localparam logic [ADDR_W-1:0] TOP_WORD = '1;

  flag_strobe_t         strobes;
  logic [NUM_SIDES-1:0] flagN;

  mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .sideSel({rightSel, leftSel}),
    .sideWr({rightWr, leftWr}),
    .sideOe({rightOe, leftOe}),
    .sideAddr({rightAddr, leftAddr}),
    .sideBusy({rightBusy, leftBusy}),
    .strobes(strobes)
  );

  mbx_flags u_flags (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .flagN(flagN)
  );

  assign leftIntN  = flagN[SIDE_LEFT];
  assign rightIntN = flagN[SIDE_RIGHT];

  // R9: reset leaves both lines inactive
  p_reset_high_r9: assert property (@(posedge clk)
    !rstN |=> (leftIntN && rightIntN));
  // R6: a busy left port cannot pull the right line low
  p_busy_no_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    leftBusy |=> !$fell(rightIntN));
  // R7: a busy right port cannot release its own line
  p_busy_no_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    rightBusy |=> !$rose(rightIntN));
  // R10: a left write anywhere but the right mailbox never pulls the right line low
  p_self_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (leftSel && leftWr && leftAddr != TOP_WORD) |=> !$fell(rightIntN));
endmodule

// File: tb/tb_mbx_irq_top.sv
module tb_mbx_irq_top;
  localparam int AW = 16;
  localparam logic [AW-1:0] RBOX = 16'hFFFF; // R1
  localparam logic [AW-1:0] LBOX = 16'hFFFE; // R1

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lSel = 0, lWr = 0, lOe = 0, lBusy = 0;
  logic rSel = 0, rWr = 0, rOe = 0, rBusy = 0;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic leftIntN, rightIntN;

  int compared = 0;
  int mismatched = 0;
  int refL = 1, refR = 1;
  string phase = "R9";
  bit finished = 0;

  always #4 clk = ~clk;

  mbx_irq_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN),
    .leftSel(lSel), .leftWr(lWr), .leftOe(lOe), .leftAddr(lAddr), .leftBusy(lBusy),
    .rightSel(rSel), .rightWr(rWr), .rightOe(rOe), .rightAddr(rAddr), .rightBusy(rBusy),
    .leftIntN(leftIntN), .rightIntN(rightIntN)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    bit setR, clrR, setL, clrL;
    setR = lSel && lWr && lAddr == RBOX && !lBusy;
    clrR = rSel && !rWr && rOe && rAddr == RBOX && !rBusy;
    setL = rSel && rWr && rAddr == LBOX && !rBusy;
    clrL = lSel && !lWr && lOe && lAddr == LBOX && !lBusy;
    if (!rstN) begin
      refL = 1; refR = 1;
    end else begin
      if (setR) refR = 0; else if (clrR) refR = 1;
      if (setL) refL = 0; else if (clrL) refL = 1;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      compared++;
      if (leftIntN !== refL[0] || rightIntN !== refR[0]) begin
        mismatched++;
        $display("FAIL %s model: actual L=%b R=%b expected L=%0d R=%0d",
                 phase, leftIntN, rightIntN, refL, refR);
      end
    end
  end

  task automatic expect_flags(input logic eL, input logic eR, input string tag);
    compared++;
    if (leftIntN !== eL || rightIntN !== eR) begin
      mismatched++;
      $display("FAIL %s: actual L=%b R=%b expected L=%b R=%b",
               tag, leftIntN, rightIntN, eL, eR);
    end
  endtask

  task automatic cyc(input logic ls, input logic lw, input logic lo, input logic [AW-1:0] la,
                     input logic lb, input logic rs, input logic rw, input logic ro,
                     input logic [AW-1:0] ra, input logic rb, input string tag);
    phase = tag;
    lSel = ls; lWr = lw; lOe = lo; lAddr = la; lBusy = lb;
    rSel = rs; rWr = rw; rOe = ro; rAddr = ra; rBusy = rb;
    @(posedge clk);
    @(negedge clk);
    lSel = 0; lWr = 0; lOe = 0; lBusy = 0;
    rSel = 0; rWr = 0; rOe = 0; rBusy = 0;
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int k = $urandom_range(0, 7);
    if (k < 3) return RBOX;
    if (k < 6) return LBOX;
    return AW'($urandom_range(0, 16'hFFFD));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    expect_flags(1, 1, "R9 during reset");
    rstN = 1;
    @(negedge clk);
    expect_flags(1, 1, "R9 after reset");

    cyc(1,1,0,RBOX,0, 0,0,0,'0,0, "R2");
    expect_flags(1, 0, "R2 left writes right mailbox (R1 0xFFFF)");
    cyc(1,0,1,RBOX,0, 0,0,0,'0,0, "R5");
    expect_flags(1, 0, "R5 left reads right mailbox");
    cyc(1,1,0,LBOX,0, 0,0,0,'0,0, "R10");
    expect_flags(1, 0, "R10 left writes own mailbox");
    cyc(0,0,0,'0,0, 1,0,1,RBOX,1, "R7");
    expect_flags(1, 0, "R7 busy right read keeps flag");
    cyc(0,0,0,'0,0, 1,0,0,RBOX,0, "R4");
    expect_flags(1, 0, "R4 read without oe keeps flag");
    cyc(0,0,0,'0,0, 1,0,1,RBOX,0, "R4");
    expect_flags(1, 1, "R4 right reads own mailbox");
    cyc(0,0,0,'0,0, 1,1,0,LBOX,0, "R3");
    expect_flags(0, 1, "R3 right writes left mailbox (R1 0xFFFE)");
    cyc(0,0,0,'0,0, 1,0,1,LBOX,0, "R5");
    expect_flags(0, 1, "R5 right reads left mailbox");
    cyc(0,0,0,'0,0, 1,1,0,RBOX,0, "R10");
    expect_flags(0, 1, "R10 right writes own mailbox");
    cyc(1,0,1,LBOX,1, 0,0,0,'0,0, "R7");
    expect_flags(0, 1, "R7 busy left read keeps flag");
    cyc(1,0,1,LBOX,0, 0,0,0,'0,0, "R4");
    expect_flags(1, 1, "R4 left reads own mailbox");
    cyc(1,1,0,RBOX,1, 0,0,0,'0,0, "R6");
    expect_flags(1, 1, "R6 busy left write blocked");
    cyc(0,0,0,'0,0, 1,1,0,LBOX,1, "R6");
    expect_flags(1, 1, "R6 busy right write blocked");
    cyc(1,1,0,RBOX,0, 1,0,1,RBOX,0, "R8");
    expect_flags(1, 0, "R8 set beats clear on right");
    cyc(1,0,1,LBOX,0, 1,1,0,LBOX,0, "R8");
    expect_flags(0, 0, "R8 set beats clear on left");
    cyc(0,1,0,LBOX,0, 0,0,1,RBOX,0, "R11");
    expect_flags(0, 0, "R11 select low ignored");
    cyc(1,0,1,16'hFFFD,0, 1,0,1,16'h0000,0, "R11");
    expect_flags(0, 0, "R11 non-mailbox reads ignored");
    cyc(1,1,0,16'h7FFF,0, 1,1,0,16'hFFFD,0, "R11");
    expect_flags(0, 0, "R11 non-mailbox writes ignored");

    phase = "random mix";
    for (int i = 0; i < 3000; i++) begin
      lSel = $urandom_range(0, 3) != 0; lWr = 1'($urandom); lOe = 1'($urandom);
      lBusy = $urandom_range(0, 3) == 0; lAddr = pick_addr();
      rSel = $urandom_range(0, 3) != 0; rWr = 1'($urandom); rOe = 1'($urandom);
      rBusy = $urandom_range(0, 3) == 0; rAddr = pick_addr();
      @(posedge clk);
      @(negedge clk);
    end

    phase = "R9";
    rstN = 0;
    @(posedge clk);
    @(negedge clk);
    expect_flags(1, 1, "R9 re-reset");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule